// File: doc/BRIEF.md
# Compare Timer with Selectable Count Source

This peripheral holds an up-counter that advances on count ticks drawn from one of three strobe inputs: a bus-clock strobe, a peripheral-clock strobe, or a crystal-oscillator strobe that can be divided down by its own small divider. A general divider then thins the selected strobe before it reaches the counter. Software sets up the block through a word-addressed register bus. To schedule an event it reads the counter, adds a delta and writes the sum to the compare register.

When the counter steps onto the compare value, a sticky status flag sets. Software clears the flag by writing one to it. A registered interrupt output is high while the flag and its enable bit are both set. In free-run mode the counter carries on past a match and wraps at its full width. With free-run off, the tick that arrives while the counter equals the compare value returns it to zero.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The counter changes only on a prescaled tick while control bit 0 is set, and it steps by exactly one per tick. While bit 0 is clear, strobes leave the counter unchanged.
- R3: Control bits 8:6 select the strobe source. Code 1 selects `tick_bus`, code 2 selects `tick_per` and code 5 selects the oscillator path. Every other code stops counting, and strobes from sources that are not selected have no effect.
- R4: Prescale bits 11:0 hold a value N that divides the selected strobe by N+1. A value of 0 passes every strobe through.
- R5: With control bit 10 set, prescale bits 15:12 hold a value M that divides `tick_osc` by M+1 before source selection (M=7 gives divide-by-8). With bit 10 clear, `tick_osc` passes undivided.
- R6: With control bit 9 set, the counter keeps counting past a compare match and wraps from all ones to zero.
- R7: With control bit 9 clear, a tick that arrives while the counter equals the compare value loads zero.
- R8: Status bit 0 (offset 0x08) sets on the tick that moves the counter onto the compare value, and it stays set afterwards.
- R9: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged. If a set event and a clear arrive in the same cycle, the flag stays set.
- R10: `irq` is registered and equals, one cycle later, status bit 0 ANDed with interrupt-enable bit 0 (offset 0x0C).
- R11: A control write that changes bit 0 from 0 to 1 clears the counter and both divider counts.
- R12: The counter reads at offset 0x24 at any time without disturbing the count. Writes to that offset are ignored.
- R13: Registers sit at byte offsets 0x00 control, 0x04 prescale, 0x08 status, 0x0C interrupt enable, 0x10 compare and 0x24 counter. Control reads back bits 0 and 10:6 only, prescale reads back bits 15:0 only, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, valid on a read |
| tick_bus | input | 1 | Bus-clock count strobe |
| tick_per | input | 1 | Peripheral-clock count strobe |
| tick_osc | input | 1 | Oscillator count strobe |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with an 8-bit counter and keeps the default divider widths and the oscillator divider. The narrow counter puts the wrap-around of free-run mode within a few hundred ticks, so a wrap followed by a fresh match can be driven directly. It also lets random compare values hit often, which exercises restart, flag set, clear collisions and interrupt gating many times over. The full 12-bit and 4-bit divider fields stay in place, so the field positions and the readback masks are checked at their real widths.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
   // register byte offsets
   localparam logic [7:0] OFF_CTRL  = 8'h00;
   localparam logic [7:0] OFF_PRESC = 8'h04;
   localparam logic [7:0] OFF_STAT  = 8'h08;
   localparam logic [7:0] OFF_IEN   = 8'h0C;
   localparam logic [7:0] OFF_CMP   = 8'h10;
   localparam logic [7:0] OFF_COUNT = 8'h24;

   localparam int NREG      = 6;
   localparam int IDX_CTRL  = 0;
   localparam int IDX_PRESC = 1;
   localparam int IDX_STAT  = 2;
   localparam int IDX_IEN   = 3;
   localparam int IDX_CMP   = 4;
   localparam int IDX_COUNT = 5;

   // control field positions
   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_SRC_LSB  = 6;
   localparam int CTRL_SRC_W    = 3;
   localparam int CTRL_FREE_BIT = 9;
   localparam int CTRL_OSCP_BIT = 10;

   // prescale field limits
   localparam int PRESC_MAIN_MAX = 12;
   localparam int PRESC_OSC_LSB  = 12;
   localparam int PRESC_OSC_MAX  = 4;

   // source select codes
   localparam logic [CTRL_SRC_W-1:0] SRC_BUS = 3'd1;
   localparam logic [CTRL_SRC_W-1:0] SRC_PER = 3'd2;
   localparam logic [CTRL_SRC_W-1:0] SRC_OSC = 3'd5;

   typedef struct packed {
      logic                  oscp_en;
      logic                  free_run;
      logic [CTRL_SRC_W-1:0] src;
      logic                  run;
   } ctrl_t;

   function automatic logic [7:0] reg_off(input int idx);
      case (idx)
         IDX_CTRL:  reg_off = OFF_CTRL;
         IDX_PRESC: reg_off = OFF_PRESC;
         IDX_STAT:  reg_off = OFF_STAT;
         IDX_IEN:   reg_off = OFF_IEN;
         IDX_CMP:   reg_off = OFF_CMP;
         default:   reg_off = OFF_COUNT;
      endcase
   endfunction
endpackage

// File: rtl/cmp_timer_div.sv
module cmp_timer_div #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         run,
   input  logic         strobe,
   input  logic [W-1:0] div,
   output logic         pulse
);
   logic [W-1:0] cnt_q;

   // >= so that lowering the divisor below the running count cannot stall
   assign pulse = run && strobe && (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (run && strobe)
         cnt_q <= pulse ? '0 : cnt_q + W'(1);
   end
endmodule

// File: rtl/cmp_timer_clksel.sv
module cmp_timer_clksel
   import cmp_timer_pkg::*;
#(
   parameter int PRE_W       = 12,
   parameter int OSC_W       = 4,
   parameter bit HAS_OSC_PRE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clear,
   input  logic                  run,
   input  logic [CTRL_SRC_W-1:0] src,
   input  logic                  oscp_en,
   input  logic [PRE_W-1:0]      pre_div,
   input  logic [OSC_W-1:0]      osc_div,
   input  logic                  tick_bus,
   input  logic                  tick_per,
   input  logic                  tick_osc,
   output logic                  tick
);
   logic osc_tick;
   logic sel_strobe;

   generate
      if (HAS_OSC_PRE) begin : g_osc_pre
         logic osc_pulse;
         cmp_timer_div #(.W(OSC_W)) u_osc_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear),
            .run    (run && oscp_en),
            .strobe (tick_osc),
            .div    (osc_div),
            .pulse  (osc_pulse)
         );
         assign osc_tick = oscp_en ? osc_pulse : tick_osc;
      end else begin : g_osc_raw
         logic unused_osc;
         assign unused_osc = ^{osc_div, oscp_en};
         assign osc_tick   = tick_osc;
      end
   endgenerate

   always_comb begin
      case (src)
         SRC_BUS: sel_strobe = tick_bus;
         SRC_PER: sel_strobe = tick_per;
         SRC_OSC: sel_strobe = osc_tick;
         default: sel_strobe = 1'b0;
      endcase
   end

   cmp_timer_div #(.W(PRE_W)) u_main_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (clear),
      .run    (run),
      .strobe (sel_strobe),
      .div    (pre_div),
      .pulse  (tick)
   );
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic             free_run,
   input  logic [CNT_W-1:0] cmp_val,
   output logic [CNT_W-1:0] count,
   output logic             match_evt
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             restart;

   assign restart   = !free_run && (cnt_q == cmp_val);
   assign cnt_nxt   = restart ? '0 : cnt_q + CNT_W'(1);
   assign match_evt = tick && (cnt_nxt == cmp_val);
   assign count     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clear)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
   import cmp_timer_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 12,
   parameter int OSC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              match_evt,
   output ctrl_t             ctrl,
   output logic [PRE_W-1:0]  pre_div,
   output logic [OSC_W-1:0]  osc_div,
   output logic [CNT_W-1:0]  cmp_val,
   output logic              run_rise,
   output logic              stat_flag,
   output logic              irq_en,
   output logic              irq
);
   logic [NREG-1:0] hit;
   logic [NREG-1:0] wr_hit;
   logic            stat_clr;
   logic            unused_wbits;

   assign unused_wbits = ^bus_wdata;

   genvar g;
   generate
      for (g = 0; g < NREG; g++) begin : g_dec
         assign hit[g]    = bus_sel && (bus_addr == ADDR_W'(reg_off(g)));
         assign wr_hit[g] = hit[g] && bus_wr;
      end
   endgenerate

   assign run_rise = wr_hit[IDX_CTRL] && bus_wdata[CTRL_RUN_BIT] && !ctrl.run;
   assign stat_clr = wr_hit[IDX_STAT] && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         pre_div <= '0;
         osc_div <= '0;
         irq_en  <= 1'b0;
         cmp_val <= '0;
      end else begin
         if (wr_hit[IDX_CTRL]) begin
            ctrl.run      <= bus_wdata[CTRL_RUN_BIT];
            ctrl.src      <= bus_wdata[CTRL_SRC_LSB +: CTRL_SRC_W];
            ctrl.free_run <= bus_wdata[CTRL_FREE_BIT];
            ctrl.oscp_en  <= bus_wdata[CTRL_OSCP_BIT];
         end
         if (wr_hit[IDX_PRESC]) begin
            pre_div <= bus_wdata[PRE_W-1:0];
            osc_div <= bus_wdata[PRESC_OSC_LSB +: OSC_W];
         end
         if (wr_hit[IDX_IEN])
            irq_en <= bus_wdata[0];
         if (wr_hit[IDX_CMP])
            cmp_val <= bus_wdata[CNT_W-1:0];
      end
   end

   // set beats clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_flag <= 1'b0;
         irq       <= 1'b0;
      end else begin
         stat_flag <= match_evt || (stat_flag && !stat_clr);
         irq       <= stat_flag && irq_en;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (!bus_wr) begin
         if (hit[IDX_CTRL]) begin
            bus_rdata[CTRL_RUN_BIT]                   = ctrl.run;
            bus_rdata[CTRL_SRC_LSB +: CTRL_SRC_W]     = ctrl.src;
            bus_rdata[CTRL_FREE_BIT]                  = ctrl.free_run;
            bus_rdata[CTRL_OSCP_BIT]                  = ctrl.oscp_en;
         end
         if (hit[IDX_PRESC]) begin
            bus_rdata[PRE_W-1:0]                      = pre_div;
            bus_rdata[PRESC_OSC_LSB +: OSC_W]         = osc_div;
         end
         if (hit[IDX_STAT])
            bus_rdata[0] = stat_flag;
         if (hit[IDX_IEN])
            bus_rdata[0] = irq_en;
         if (hit[IDX_CMP])
            bus_rdata[CNT_W-1:0] = cmp_val;
         if (hit[IDX_COUNT])
            bus_rdata[CNT_W-1:0] = count;
      end
   end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import cmp_timer_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int CNT_W       = 32,
   parameter int PRE_W       = 12,
   parameter int OSC_W       = 4,
   parameter bit HAS_OSC_PRE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tick_bus,
   input  logic              tick_per,
   input  logic              tick_osc,
   output logic              irq
);
   generate
      if (ADDR_W < 6 || ADDR_W > 8) begin : g_bad_addr
         $error("cmp_timer: ADDR_W must lie in 6..8");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("cmp_timer: CNT_W must lie in 2..32");
      end
      if (PRE_W < 1 || PRE_W > PRESC_MAIN_MAX) begin : g_bad_pre
         $error("cmp_timer: PRE_W out of range");
      end
      if (OSC_W < 1 || OSC_W > PRESC_OSC_MAX) begin : g_bad_osc
         $error("cmp_timer: OSC_W out of range");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [PRE_W-1:0] pre_div;
   logic [OSC_W-1:0] osc_div;
   logic [CNT_W-1:0] cmp_val;
   logic [CNT_W-1:0] count_q;
   logic             run_rise;
   logic             stat_flag;
   logic             irq_en;
   logic             match_evt;
   logic             tick;

   cmp_timer_regs #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .PRE_W  (PRE_W),
      .OSC_W  (OSC_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .count     (count_q),
      .match_evt (match_evt),
      .ctrl      (ctrl_q),
      .pre_div   (pre_div),
      .osc_div   (osc_div),
      .cmp_val   (cmp_val),
      .run_rise  (run_rise),
      .stat_flag (stat_flag),
      .irq_en    (irq_en),
      .irq       (irq)
   );

   cmp_timer_clksel #(
      .PRE_W       (PRE_W),
      .OSC_W       (OSC_W),
      .HAS_OSC_PRE (HAS_OSC_PRE)
   ) u_clksel (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (run_rise),
      .run      (ctrl_q.run),
      .src      (ctrl_q.src),
      .oscp_en  (ctrl_q.oscp_en),
      .pre_div  (pre_div),
      .osc_div  (osc_div),
      .tick_bus (tick_bus),
      .tick_per (tick_per),
      .tick_osc (tick_osc),
      .tick     (tick)
   );

   cmp_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (run_rise),
      .tick      (tick),
      .free_run  (ctrl_q.free_run),
      .cmp_val   (cmp_val),
      .count     (count_q),
      .match_evt (match_evt)
   );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
   import cmp_timer_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              run,
   input logic [CNT_W-1:0]  count,
   input logic              match_evt,
   input logic              stat,
   input logic              ien,
   input logic              irq
);
   logic w_ctrl;
   logic w_clr;

   assign w_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
   assign w_clr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_STAT)) && bus_wdata[0];

   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !w_ctrl) |=> $stable(count)); // R2

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !w_ctrl) |=> (count == $past(count) || count == $past(count) + CNT_W'(1) || count == '0)); // R2

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (w_ctrl && bus_wdata[0] && !run) |=> (count == '0)); // R11

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> stat); // R9

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat && !w_clr) |=> stat); // R9

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat && !match_evt) |=> !stat); // R8

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(ien) && $past(stat))); // R10
endmodule

bind cmp_timer cmp_timer_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .run       (ctrl_q.run),
   .count     (count_q),
   .match_evt (match_evt),
   .stat      (stat_flag),
   .ien       (irq_en),
   .irq       (irq)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 6;
   localparam int CNT_W      = 8;
   localparam int PRE_W      = 12;
   localparam int OSC_W      = 4;

   localparam logic [5:0] A_CTRL  = 6'h00;
   localparam logic [5:0] A_PRESC = 6'h04;
   localparam logic [5:0] A_STAT  = 6'h08;
   localparam logic [5:0] A_IEN   = 6'h0C;
   localparam logic [5:0] A_CMP   = 6'h10;
   localparam logic [5:0] A_COUNT = 6'h24;
   localparam logic [5:0] A_HOLE  = 6'h3C;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic              tick_bus = 1'b0;
   logic              tick_per = 1'b0;
   logic              tick_osc = 1'b0;
   logic              irq;

   int n_chk = 0;
   int n_bad = 0;

   cmp_timer #(
      .ADDR_W      (ADDR_W),
      .CNT_W       (CNT_W),
      .PRE_W       (PRE_W),
      .OSC_W       (OSC_W),
      .HAS_OSC_PRE (1'b1)
   ) u_cmp_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tick_bus  (tick_bus),
      .tick_per  (tick_per),
      .tick_osc  (tick_osc),
      .irq       (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- reference model, built from the requirements ----------------
   logic             m_run, m_free, m_oscp, m_stat, m_ie, m_irq;
   logic [2:0]       m_src;
   logic [PRE_W-1:0] m_pre, m_pc;
   logic [OSC_W-1:0] m_osc, m_oc;
   logic [CNT_W-1:0] m_cmp, m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_free = 0; m_oscp = 0; m_stat = 0; m_ie = 0; m_irq = 0;
         m_src = 0; m_pre = 0; m_pc = 0; m_osc = 0; m_oc = 0; m_cmp = 0; m_cnt = 0;
      end else begin
         automatic logic ot, st, t, evt, clr;
         automatic logic [CNT_W-1:0] nxt;
         ot = tick_osc;                                   // R5
         if (m_oscp) begin
            ot = m_run && tick_osc && (m_oc >= m_osc);
            if (m_run && tick_osc) m_oc = ot ? '0 : m_oc + 1'b1;
         end
         case (m_src)                                     // R3
            3'd1:    st = tick_bus;
            3'd2:    st = tick_per;
            3'd5:    st = ot;
            default: st = 1'b0;
         endcase
         t = m_run && st && (m_pc >= m_pre);              // R4
         if (m_run && st) m_pc = t ? '0 : m_pc + 1'b1;
         evt = 1'b0;
         if (t) begin                                     // R6 R7
            nxt   = (!m_free && m_cnt == m_cmp) ? '0 : m_cnt + 1'b1;
            evt   = (nxt == m_cmp);
            m_cnt = nxt;
         end
         m_irq = m_stat & m_ie;                           // R10
         clr = bus_sel && bus_wr && bus_addr == A_STAT && bus_wdata[0];
         m_stat = evt | (m_stat & ~clr);                  // R8 R9
         if (bus_sel && bus_wr) begin
            case (bus_addr)
               A_CTRL: begin
                  if (!m_run && bus_wdata[0]) begin       // R11
                     m_cnt = '0; m_pc = '0; m_oc = '0;
                  end
                  m_run  = bus_wdata[0];
                  m_src  = bus_wdata[8:6];
                  m_free = bus_wdata[9];
                  m_oscp = bus_wdata[10];
               end
               A_PRESC: begin
                  m_pre = bus_wdata[11:0];
                  m_osc = bus_wdata[15:12];
               end
               A_IEN:   m_ie  = bus_wdata[0];
               A_CMP:   m_cmp = bus_wdata[CNT_W-1:0];
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [5:0] a);
      case (a)
         A_CTRL:  exp_rd = {21'b0, m_oscp, m_free, m_src, 5'b0, m_run};
         A_PRESC: exp_rd = {16'b0, m_osc, m_pre};
         A_STAT:  exp_rd = {31'b0, m_stat};
         A_IEN:   exp_rd = {31'b0, m_ie};
         A_CMP:   exp_rd = {24'b0, m_cmp};
         A_COUNT: exp_rd = {24'b0, m_cnt};
         default: exp_rd = 32'b0;
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] a);
      case (a)
         A_COUNT: tag_of = "R12";
         A_STAT:  tag_of = "R8";
         default: tag_of = "R13";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison, a quarter period after the edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n) begin
         check(irq == m_irq, "R10", {31'b0, irq}, {31'b0, m_irq});
         if (bus_sel && !bus_wr)
            check(bus_rdata == exp_rd(bus_addr), tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
      end
   end

   task automatic drive(input logic w, input logic [5:0] a, input logic [31:0] d,
                        input logic tb, input logic tp, input logic to);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
      tick_bus = tb; tick_per = tp; tick_osc = to;
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      drive(1'b1, a, d, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic pulse(input int n, input logic tb, input logic tp, input logic to);
      for (int i = 0; i < n; i++) drive(1'b0, A_COUNT, 32'b0, tb, tp, to);
   endtask

   task automatic expect_rd(input logic [5:0] a, input logic [31:0] exp, input string req);
      drive(1'b0, a, 32'b0, 1'b0, 1'b0, 1'b0);
      @(posedge clk);
      #(CLK_PERIOD/4);
      check(bus_rdata == exp, req, bus_rdata, exp);
   endtask

   task automatic expect_irq(input logic exp, input string req);
      drive(1'b0, A_IEN, 32'b0, 1'b0, 1'b0, 1'b0);
      @(posedge clk);
      #(CLK_PERIOD/4);
      check(irq == exp, req, {31'b0, irq}, {31'b0, exp});
   endtask

   task automatic summary;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_rd(A_CTRL, 32'h0, "R1");
      expect_rd(A_STAT, 32'h0, "R1");
      expect_rd(A_COUNT, 32'h0, "R1");
      expect_irq(1'b0, "R1");

      // R13 readback masks and unmapped hole
      wr(A_CTRL, 32'hFFFF_FFFE);
      expect_rd(A_CTRL, 32'h0000_07C0, "R13");
      wr(A_CTRL, 32'h0);
      wr(A_PRESC, 32'hFFFF_FFFF);
      expect_rd(A_PRESC, 32'h0000_FFFF, "R13");
      expect_rd(A_HOLE, 32'h0, "R13");
      wr(A_PRESC, 32'h0);

      // R2 / R3 bus source, run gating
      wr(A_CMP, 32'd200);
      wr(A_CTRL, 32'h41);
      pulse(5, 1, 0, 0);
      expect_rd(A_COUNT, 32'd5, "R2");
      pulse(3, 0, 1, 1);
      expect_rd(A_COUNT, 32'd5, "R3");
      wr(A_CTRL, 32'h40);
      pulse(3, 1, 0, 0);
      expect_rd(A_COUNT, 32'd5, "R2");

      // R11 start clears
      wr(A_CTRL, 32'h41);
      expect_rd(A_COUNT, 32'd0, "R11");

      // R3 peripheral source and an unused code
      wr(A_CTRL, 32'h81);
      pulse(4, 0, 1, 0);
      pulse(2, 1, 0, 0);
      expect_rd(A_COUNT, 32'd4, "R3");
      wr(A_CTRL, 32'hC1);
      pulse(3, 1, 1, 1);
      expect_rd(A_COUNT, 32'd4, "R3");

      // R4 main divider by 3
      wr(A_CTRL, 32'h41);
      wr(A_PRESC, 32'd2);
      pulse(7, 1, 0, 0);
      expect_rd(A_COUNT, 32'd6, "R4");

      // R5 oscillator divider by 8, then bypass
      wr(A_PRESC, 32'h0000_7000);
      wr(A_CTRL, 32'h541);
      pulse(16, 0, 0, 1);
      expect_rd(A_COUNT, 32'd8, "R5");
      wr(A_CTRL, 32'h141);
      pulse(3, 0, 0, 1);
      expect_rd(A_COUNT, 32'd11, "R5");

      // R8 / R7 match and restart
      wr(A_PRESC, 32'h0);
      wr(A_CTRL, 32'h41);
      wr(A_CMP, 32'd13);
      pulse(2, 1, 0, 0);
      expect_rd(A_STAT, 32'd1, "R8");
      pulse(1, 1, 0, 0);
      expect_rd(A_COUNT, 32'd0, "R7");
      expect_rd(A_STAT, 32'd1, "R8");

      // R9 write-one-to-clear
      wr(A_STAT, 32'h0);
      expect_rd(A_STAT, 32'd1, "R9");
      wr(A_STAT, 32'h1);
      expect_rd(A_STAT, 32'd0, "R9");
      pulse(12, 1, 0, 0);
      drive(1'b1, A_STAT, 32'h1, 1'b1, 1'b0, 1'b0);
      expect_rd(A_STAT, 32'd1, "R9");

      // R10 interrupt gating
      wr(A_IEN, 32'h1);
      expect_irq(1'b1, "R10");
      wr(A_IEN, 32'h0);
      expect_irq(1'b0, "R10");

      // R12 counter is read-only
      wr(A_COUNT, 32'hDEAD_BEEF);
      expect_rd(A_COUNT, 32'd13, "R12");

      // R6 free-run wrap
      wr(A_CTRL, 32'h241);
      pulse(300, 1, 0, 0);
      expect_rd(A_COUNT, 32'd57, "R6");

      // random phase, checked against the model every cycle
      for (int c = 0; c < 6000; c++) begin
         automatic int r = $urandom % 100;
         automatic logic [5:0] a;
         automatic logic [31:0] d = $urandom;
         automatic int pick = $urandom % 7;
         case (pick)
            0: a = A_CTRL;  1: a = A_PRESC; 2: a = A_STAT; 3: a = A_IEN;
            4: a = A_CMP;   5: a = A_COUNT; default: a = A_HOLE;
         endcase
         if (r < 8) begin
            if (a == A_CTRL) begin
               automatic int s = $urandom % 5;
               d[0] = ($urandom % 8) != 0;
               d[8:6] = (s == 4) ? 3'd5 : 3'(s);
            end
            if (a == A_PRESC) begin
               d[11:0]  = 12'($urandom % 4);
               d[15:12] = 4'($urandom % 4);
            end
            drive(1'b1, a, d, 1'($urandom), 1'($urandom), 1'($urandom));
         end else begin
            drive(1'b0, a, 32'b0, 1'($urandom), 1'($urandom), 1'($urandom));
         end
      end
      expect_rd(A_COUNT, exp_rd(A_COUNT), "R12");

      summary();
      $finish;
   end
endmodule